// File: doc/BRIEF.md
# Configuration Register Access Gate with No-EEPROM Fallback

This block accepts decoded register requests from a serial interface front end. Each request carries a 7-bit address, a read/write flag and one data byte. The block decides whether to serve each request. It then returns one response carrying an acknowledge flag and a read byte. Three areas sit behind it:

- a small configuration RAM held inside the block, whose contents drive the rest of the chip;
- a fixed identification ROM;
- an EEPROM-backed bank area, reached through a plain strobe port.

Whether an EEPROM is attached changes the rules. With an EEPROM present, a 2-bit protection setting and a configured timeout choice apply. Without one, the block runs in fallback mode so that the device can still be set up over the interface:

- protection is treated as fully open;
- the configured timeout choice is ignored;
- only the configuration area and the identification bytes respond.

Two writes have side effects. A write to address 0x00, which is the last step of a configuration sequence, raises a one-cycle internal reset request. Writing the key 0x07 to identification address 0x7C selects the short interface timeout until the next reset.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next edge and stays unchanged until `rsp_ready` takes it. Only one request is in flight at a time, so `req_ready` is low while an untaken response is held.

Top module: `cfg_access_gate`

## Requirements
- R1: After `rst_n` is released, `rsp_valid` is 0, `req_ready` is 1, `tmo_short` is 0 and every configuration byte on `cfg_image` is 0x00.
- R2: A request taken at an edge gives `rsp_valid` = 1 after that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_ack` and `rsp_rdata` stay stable.
- R3: When accepted, addresses 0x00–0x0C read and write the configuration RAM. Byte k appears on `cfg_image[8k+7:8k]`, and a read returns the last value written.
- R4: An accepted write to address 0x00 stores its data and drives `cfg_reset` high for exactly the one cycle after the accepting edge.
- R5: With `eeprom_present` = 0, the protection setting has no effect: configuration reads and writes are acknowledged for every `prot_level`.
- R6: With `eeprom_present` = 1, `prot_level` 0 allows everything. `prot_level` 1 refuses writes to 0x00–0x77 and still allows reads there. `prot_level` 2 or 3 refuses all accesses to 0x00–0x77.
- R7: With `eeprom_present` = 0, any access to 0x0D–0x77 is refused and raises neither `ext_we` nor `ext_re`.
- R8: With `eeprom_present` = 1, an allowed access to 0x0D–0x77 pulses `ext_re` or `ext_we` in the accepting cycle, with `ext_addr`/`ext_wdata` valid. A read returns `ext_rdata` sampled in that cycle.
- R9: Reads of 0x78–0x7F are always acknowledged and return byte (addr−0x78) of `ID_WORD`, counting from its least significant byte. Writes there are refused, with the single exception in R10.
- R10: A write of 0x07 to 0x7C is acknowledged under any protection setting and sets `tmo_short` after the accepting edge. Any other value written there is refused, changes nothing, and leaves the byte read from 0x7C unchanged.
- R11: `tmo_short` is the stored short-timeout flag OR'd with `cfg_tmo_short`. The `cfg_tmo_short` input takes part only when `eeprom_present` = 1.
- R12: The stored short-timeout flag is cleared by `rst_n` and by the `cfg_reset` pulse.
- R13: A refused access gives `rsp_ack` = 0 and `rsp_rdata` = 0x00. An acknowledged write also returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eeprom_present | input | 1 | 1 when configuration was loaded from an EEPROM; 0 selects fallback mode |
| prot_level | input | 2 | Register protection setting (ignored in fallback) |
| cfg_tmo_short | input | 1 | Configured short-timeout choice (ignored in fallback) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_ack | output | 1 | 1 = access served, 0 = refused |
| rsp_rdata | output | 8 | Read data, 0x00 for writes and refusals |
| ext_we | output | 1 | Bank-area write strobe |
| ext_re | output | 1 | Bank-area read strobe |
| ext_addr | output | 7 | Bank-area address |
| ext_wdata | output | 8 | Bank-area write data |
| ext_rdata | input | 8 | Bank-area read data, valid in the strobe cycle |
| cfg_reset | output | 1 | One-cycle internal reset request |
| tmo_short | output | 1 | 1 selects the short interface timeout |
| cfg_image | output | 104 | Configuration RAM contents, byte k at bits 8k+7:8k |

## Verification
The access decision is driven with a table of requests that sweeps each of the three address areas, both directions, both EEPROM states and several protection levels. This separates:

- a block that honours protection in fallback from one that opens it;
- bank forwarding from refusal;
- identification reads from refused identification writes.

Readback after a refused write shows whether stored data was disturbed. Directed sequences then cover:

- the reset pulse and its clearing of the short-timeout flag;
- the key versus non-key writes to 0x7C;
- the gating of the configured timeout by EEPROM presence;
- a response held under back-pressure.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [1:0] {
    RG_CFG = 2'd0,
    RG_EXT = 2'd1,
    RG_ID  = 2'd2
  } region_e;
endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
  import cfg_access_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int CFG_LAST = 12,
  parameter int ID_BASE  = 120,
  parameter int TMO_ADDR = 124,
  parameter int TMO_KEY  = 7
) (
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  input  logic          eep,
  input  logic [1:0]    prot,
  output region_e       region,
  output logic          accept,
  output logic          special
);
  localparam logic [AW-1:0] A_LAST = AW'(CFG_LAST);
  localparam logic [AW-1:0] A_ID   = AW'(ID_BASE);
  localparam logic [AW-1:0] A_TMO  = AW'(TMO_ADDR);
  localparam logic [DW-1:0] K_TMO  = DW'(TMO_KEY);

  logic [1:0] eff_prot;
  logic       open_rd;
  logic       open_wr;

  // Fallback mode behaves as protection level zero.
  assign eff_prot = eep ? prot : 2'd0;
  assign open_wr  = (eff_prot == 2'd0);
  assign open_rd  = (eff_prot <= 2'd1);
  assign special  = write && (addr == A_TMO) && (wdata == K_TMO);

  always_comb begin
    if (addr <= A_LAST)     region = RG_CFG;
    else if (addr >= A_ID)  region = RG_ID;
    else                    region = RG_EXT;
  end

  always_comb begin
    unique case (region)
      RG_CFG:  accept = write ? open_wr : open_rd;
      RG_EXT:  accept = eep && (write ? open_wr : open_rd);
      RG_ID:   accept = !write || special;
      default: accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_access_ram.sv
module cfg_access_ram #(
  parameter int N  = 13,
  parameter int DW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [N*DW-1:0] image
);
  logic [DW-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (we && (idx == IW'(i)))      mem[i] <= wdata;
    end
    assign image[i*DW +: DW] = mem[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (idx == IW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/cfg_access_idrom.sv
module cfg_access_idrom #(
  parameter int          DW      = 8,
  parameter int          N       = 8,
  parameter logic [N*DW-1:0] ID_WORD = '0,
  localparam int         IW      = $clog2(N)
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (idx == IW'(i)) rdata = ID_WORD[i*DW +: DW];
  end
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_access_pkg::*;
#(
  parameter int          AW       = 7,
  parameter int          DW       = 8,
  parameter int          CFG_LAST = 12,
  parameter int          ID_BASE  = 120,
  parameter int          ID_N     = 8,
  parameter int          TMO_ADDR = 124,
  parameter int          TMO_KEY  = 7,
  parameter logic [63:0] ID_WORD  = 64'hC54E_1702_10D0_3A69,
  localparam int         CFG_N    = CFG_LAST + 1,
  localparam int         CIW      = $clog2(CFG_N),
  localparam int         RIW      = $clog2(ID_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eeprom_present,
  input  logic [1:0]          prot_level,
  input  logic                cfg_tmo_short,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_ack,
  output logic [DW-1:0]       rsp_rdata,
  output logic                ext_we,
  output logic                ext_re,
  output logic [AW-1:0]       ext_addr,
  output logic [DW-1:0]       ext_wdata,
  input  logic [DW-1:0]       ext_rdata,
  output logic                cfg_reset,
  output logic                tmo_short,
  output logic [CFG_N*DW-1:0] cfg_image
);
  region_e       region;
  logic          accept;
  logic          special;
  logic          fire;
  logic          ram_we;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] rom_rdata;
  logic [DW-1:0] rd_mux;
  logic          short_flag;

  cfg_access_decode #(
    .AW(AW), .DW(DW), .CFG_LAST(CFG_LAST), .ID_BASE(ID_BASE),
    .TMO_ADDR(TMO_ADDR), .TMO_KEY(TMO_KEY)
  ) u_decode (
    .addr(req_addr), .write(req_write), .wdata(req_wdata),
    .eep(eeprom_present), .prot(prot_level),
    .region(region), .accept(accept), .special(special)
  );

  cfg_access_ram #(.N(CFG_N), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(req_addr[CIW-1:0]),
    .wdata(req_wdata), .rdata(ram_rdata), .image(cfg_image)
  );

  cfg_access_idrom #(.DW(DW), .N(ID_N), .ID_WORD(ID_WORD[ID_N*DW-1:0])) u_rom (
    .idx(req_addr[RIW-1:0]), .rdata(rom_rdata)
  );

  // One request in flight; a new one is taken as the held response leaves.
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign ram_we    = fire && accept && req_write && (region == RG_CFG);
  assign ext_we    = fire && accept && req_write  && (region == RG_EXT);
  assign ext_re    = fire && accept && !req_write && (region == RG_EXT);
  assign ext_addr  = req_addr;
  assign ext_wdata = req_wdata;

  always_comb begin
    unique case (region)
      RG_CFG:  rd_mux = ram_rdata;
      RG_EXT:  rd_mux = ext_rdata;
      RG_ID:   rd_mux = rom_rdata;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_ack   <= accept;
      rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_reset <= 1'b0;
    else        cfg_reset <= ram_we && (req_addr == '0);
  end

  // A key write sets the flag; the internal reset pulse clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  short_flag <= 1'b0;
    else if (fire && special)    short_flag <= 1'b1;
    else if (cfg_reset)          short_flag <= 1'b0;
  end

  assign tmo_short = short_flag || (eeprom_present && cfg_tmo_short);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata)));

  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reset |=> !cfg_reset);

  a_r13_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |-> (rsp_rdata == '0));

  a_r7_quiet_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !eeprom_present |-> (!ext_we && !ext_re));

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_we, ext_re}));

  a_r12_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reset && !fire && !(eeprom_present && cfg_tmo_short)) |=> !tmo_short);
endmodule

// File: tb/cfg_access_gate_tb.sv
module cfg_access_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eeprom_present = 1'b0;
  logic [1:0]  prot_level = 2'd0;
  logic        cfg_tmo_short = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_ack;
  logic [7:0]  rsp_rdata;
  logic        ext_we, ext_re;
  logic [6:0]  ext_addr;
  logic [7:0]  ext_wdata;
  logic [7:0]  ext_rdata;
  logic        cfg_reset;
  logic        tmo_short;
  logic [103:0] cfg_image;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0] last_wa = '0;
  logic [7:0] last_wd = '0;

  localparam logic [63:0] IDW = 64'hC54E_1702_10D0_3A69;

  always #2.5 clk = ~clk;

  // Bank-area model: read data is a fixed function of the address.
  assign ext_rdata = {1'b0, ext_addr} ^ 8'hC3;
  always @(posedge clk) if (ext_we) begin last_wa <= ext_addr; last_wd <= ext_wdata; end

  cfg_access_gate u_dut (
    .clk(clk), .rst_n(rst_n), .eeprom_present(eeprom_present), .prot_level(prot_level),
    .cfg_tmo_short(cfg_tmo_short), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .ext_we(ext_we), .ext_re(ext_re), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .cfg_reset(cfg_reset), .tmo_short(tmo_short), .cfg_image(cfg_image)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check strobes just after, response at the next falling edge.
  task automatic access(input logic wr, input logic [6:0] a, input logic [7:0] d,
                        input logic exp_ext, input logic ack, input logic [7:0] rd,
                        input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    chk({req, " ext_we"}, {31'd0, ext_we}, {31'd0, exp_ext && wr});
    chk({req, " ext_re"}, {31'd0, ext_re}, {31'd0, exp_ext && !wr});
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " rsp_ack"}, {31'd0, rsp_ack}, {31'd0, ack});
    chk({req, " rsp_rdata"}, {24'd0, rsp_rdata}, {24'd0, rd});
  endtask

  // {req#[3:0], eep, prot[1:0], wr, addr[6:0], wdata[7:0], ack, rdata[7:0]}
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    {4'd3,  1'b0, 2'd0, 1'b1, 7'h05, 8'hA5, 1'b1, 8'h00},  // R3 write
    {4'd3,  1'b0, 2'd0, 1'b0, 7'h05, 8'h00, 1'b1, 8'hA5},  // R3 readback
    {4'd5,  1'b0, 2'd2, 1'b1, 7'h0C, 8'h3C, 1'b1, 8'h00},  // R5 prot ignored
    {4'd5,  1'b0, 2'd2, 1'b0, 7'h0C, 8'h00, 1'b1, 8'h3C},  // R5
    {4'd7,  1'b0, 2'd0, 1'b0, 7'h20, 8'h00, 1'b0, 8'h00},  // R7 read refused
    {4'd7,  1'b0, 2'd0, 1'b1, 7'h40, 8'h99, 1'b0, 8'h00},  // R7 write refused
    {4'd9,  1'b0, 2'd0, 1'b0, 7'h78, 8'h00, 1'b1, 8'h69},  // R9 first id byte
    {4'd9,  1'b0, 2'd0, 1'b0, 7'h7F, 8'h00, 1'b1, 8'hC5},  // R9 last id byte
    {4'd9,  1'b0, 2'd0, 1'b1, 7'h78, 8'h11, 1'b0, 8'h00},  // R9 write refused
    {4'd8,  1'b1, 2'd0, 1'b0, 7'h20, 8'h00, 1'b1, 8'hE3},  // R8 bank read
    {4'd8,  1'b1, 2'd0, 1'b1, 7'h30, 8'h77, 1'b1, 8'h00},  // R8 bank write
    {4'd6,  1'b1, 2'd1, 1'b1, 7'h05, 8'hFF, 1'b0, 8'h00},  // R6 write locked
    {4'd6,  1'b1, 2'd1, 1'b0, 7'h05, 8'h00, 1'b1, 8'hA5},  // R6 read open, data kept
    {4'd6,  1'b1, 2'd2, 1'b0, 7'h05, 8'h00, 1'b0, 8'h00},  // R6 R13 read locked
    {4'd9,  1'b1, 2'd2, 1'b0, 7'h7A, 8'h00, 1'b1, 8'hD0},  // R9 id under lock
    {4'd6,  1'b1, 2'd1, 1'b0, 7'h21, 8'h00, 1'b1, 8'hE2},  // R6 bank read at level 1
    {4'd6,  1'b1, 2'd3, 1'b1, 7'h22, 8'h55, 1'b0, 8'h00}   // R6 bank write locked
  };

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R1 tmo_short", {31'd0, tmo_short}, 32'd0);
    chk("R1 cfg_image", {31'd0, cfg_image == '0}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      logic        ext;
      string       tag;
      v = VEC[i];
      eeprom_present = v[27];
      prot_level = v[26:25];
      ext = v[27] && (v[23:17] >= 7'h0D) && (v[23:17] <= 7'h77) && v[8];
      tag = $sformatf("R%0d vec%0d", v[31:28], i);
      access(v[24], v[23:17], v[16:9], ext, v[8], v[7:0], tag);
    end
    chk("R8 bank write addr", {25'd0, last_wa}, 32'h30);
    chk("R8 bank write data", {24'd0, last_wd}, 32'h77);
    chk("R3 image byte 5", {24'd0, cfg_image[47:40]}, 32'hA5);
    chk("R3 image byte 12", {24'd0, cfg_image[103:96]}, 32'h3C);

    // R4 reset request pulse
    eeprom_present = 1'b0; prot_level = 2'd0;
    access(1'b1, 7'h00, 8'h81, 1'b0, 1'b1, 8'h00, "R4 write 0x00");
    chk("R4 pulse high", {31'd0, cfg_reset}, 32'd1);
    @(negedge clk);
    chk("R4 pulse low", {31'd0, cfg_reset}, 32'd0);
    chk("R4 byte 0 stored", {24'd0, cfg_image[7:0]}, 32'h81);

    // R10 key and non-key writes to the timeout address
    access(1'b1, 7'h7C, 8'h06, 1'b0, 1'b0, 8'h00, "R10 non-key");
    chk("R10 non-key no effect", {31'd0, tmo_short}, 32'd0);
    access(1'b1, 7'h7C, 8'h07, 1'b0, 1'b1, 8'h00, "R10 key");
    chk("R10 short set", {31'd0, tmo_short}, 32'd1);
    access(1'b0, 7'h7C, 8'h00, 1'b0, 1'b1, 8'h02, "R10 id byte unchanged");

    // R12 internal reset clears the flag
    access(1'b1, 7'h00, 8'h00, 1'b0, 1'b1, 8'h00, "R12 write 0x00");
    chk("R12 flag held during pulse", {31'd0, tmo_short}, 32'd1);
    @(negedge clk);
    chk("R12 flag cleared", {31'd0, tmo_short}, 32'd0);

    // R11 configured timeout only with an EEPROM
    cfg_tmo_short = 1'b1; #1;
    chk("R11 ignored in fallback", {31'd0, tmo_short}, 32'd0);
    eeprom_present = 1'b1; #1;
    chk("R11 used with eeprom", {31'd0, tmo_short}, 32'd1);
    cfg_tmo_short = 1'b0;

    // R10 key accepted even under full protection
    prot_level = 2'd3;
    access(1'b1, 7'h7C, 8'h07, 1'b0, 1'b1, 8'h00, "R10 key locked");
    chk("R10 short set locked", {31'd0, tmo_short}, 32'd1);

    // R2 back-pressure
    eeprom_present = 1'b0; prot_level = 2'd0;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 7'h05;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 valid", {31'd0, rsp_valid}, 32'd1);
    chk("R2 busy", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R2 still valid", {31'd0, rsp_valid}, 32'd1);
    chk("R2 data held", {24'd0, rsp_rdata}, 32'hA5);
    rsp_ready = 1'b1; #1;
    chk("R2 ready follows", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk("R2 drained", {31'd0, rsp_valid}, 32'd0);

    // R12 R1 external reset clears the flag
    rst_n = 1'b0; #1;
    chk("R12 rst clears flag", {31'd0, tmo_short}, 32'd0);
    chk("R1 rst clears image", {31'd0, cfg_image == '0}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule